// File: doc/BRIEF.md
# Link Detect and Polling Sequencer

This block steps a serial link of up to eight lanes through the first part of link training. After reset it waits in a quiet detect state. It leaves that state when a cycle-count timeout (standing in for a 12 ms interval) expires, or as soon as any lane reports an exit from electrical idle. It then spends one cycle in an active detect state. There it records which lanes found a receiver at the far end. If no lane did, it returns to the quiet state and starts the timer again. Otherwise it moves on to active polling.

While polling, the block enables transmission of training sets on the recorded lanes and counts the training sets the transmitter reports as sent. It also keeps a run counter for each lane, which tracks consecutive received training sets. Both kinds of training set count, in any mix and in either polarity. When enough sets have been sent and every recorded lane has a full run, the block moves to a polling-configuration state and raises a done flag. It holds there until reset. Symbol lock, ordered-set decoding and the states that follow are handled elsewhere.

Top module: `link_poll_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the state output is 0 (quiet), the lane transmit enables are all 0 and the done flag is 0. State codes: 0 quiet, 1 active detect, 2 active polling, 3 polling configuration.
- R2: Without any idle exit, the quiet state lasts exactly QUIET_CYCLES clock edges after it is entered. The state becomes 1 on the following edge.
- R3: An idle-exit flag on any lane, seen at an edge while in the quiet state, moves the state to 1 at that same edge.
- R4: The active detect state lasts one cycle. If the receiver-present vector is all zero in that cycle, the next state is 0 and the quiet timer restarts from zero.
- R5: If any receiver-present bit is set in the active detect cycle, the next state is 2. The vector is captured as the lane mask. The transmit enable output equals that mask in states 2 and 3 and is 0 in states 0 and 1.
- R6: The state cannot leave 2 until TX_TARGET sent-strobes have been counted in state 2. This holds even when every lane run is already complete.
- R7: The state cannot leave 2 until every masked lane has RUN_LEN consecutive counted sets. Lanes outside the mask have no effect on the exit.
- R8: A received set whose 2-bit kind is 01 (first training set) or 10 (second training set) adds one to that lane's run. The two kinds may be mixed, and the inverted-polarity flag does not stop a set from counting.
- R9: A received set of kind 00 or 11 clears that lane's run to zero.
- R10: When the sent count and all masked runs are complete, the state becomes 3 on the next edge. The done flag is then 1, and both stay so until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_present | input | LANES | Receiver found at far end, per lane |
| eidle_exit | input | LANES | Electrical idle exit seen, per lane |
| os_valid | input | LANES | Received ordered-set strobe, per lane |
| os_kind | input | 2*LANES | Kind of received set, 2 bits per lane (01, 10 training; others not) |
| os_inverted | input | LANES | Received set arrived in complemented form |
| ts1_sent | input | 1 | One training set transmitted on the link |
| ltssm_state | output | 2 | Current state code |
| tx_lane_en | output | LANES | Per-lane training-set transmit enable |
| poll_done | output | 1 | Polling configuration reached |

## Verification
All outputs come from registers. A stimulus applied before an edge therefore shows in the state one edge later. Because the exit test reads the registered counters, the final strobe or received set that completes polling is absorbed at one edge and changes the state at the next edge. The bench drives inputs at the falling edge and samples at the falling edge after each rising edge. For every check it counts the edges from the stimulus, using this two-step rule for the polling exit and QUIET_CYCLES+1 edges for the timeout. It sweeps every receiver-present pattern of a four-lane instance.

// File: rtl/lps_pkg.sv
package lps_pkg;
   typedef enum logic [1:0] {
      LS_QUIET  = 2'd0,
      LS_DETECT = 2'd1,
      LS_POLL   = 2'd2,
      LS_CFG    = 2'd3
   } lseq_state_t;

   localparam logic [1:0] OSK_TS1 = 2'b01;
   localparam logic [1:0] OSK_TS2 = 2'b10;
endpackage

// File: rtl/lps_sat_ctr.sv
module lps_sat_ctr #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic done
);
   localparam int W = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("lps_sat_ctr: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt_q;

   assign done = (cnt_q == W'(LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr)          cnt_q <= '0;
      else if (inc && !done) cnt_q <= cnt_q + W'(1);
   end

   // R2 / R6: the count saturates at its limit
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= W'(LIMIT));
endmodule

// File: rtl/lps_lane_run.sv
module lps_lane_run
   import lps_pkg::*;
#(
   parameter int unsigned RUN_LEN = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic       os_valid,
   input  logic [1:0] os_kind,
   input  logic       os_inv,
   output logic       run_done
);
   localparam int W = $clog2(RUN_LEN + 1);

   if (RUN_LEN < 1) begin : g_bad_run
      $error("lps_lane_run: RUN_LEN must be at least 1");
   end

   logic [W-1:0] run_q;
   logic         is_ts;

   assign is_ts    = (os_kind == OSK_TS1) || (os_kind == OSK_TS2);
   assign run_done = (run_q == W'(RUN_LEN));

   always_ff @(posedge clk) begin
      if (!rst_n)                 run_q <= '0;
      else if (clr)               run_q <= '0;
      else if (en && os_valid) begin
         if (!is_ts)              run_q <= '0;
         else if (!run_done)      run_q <= run_q + W'(1);
      end
   end

   // R9: a non-training set empties the run
   p_run_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && en && os_valid && !is_ts) |=> (run_q == '0));

   // R8: complemented training sets still extend the run
   p_inv_counts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && en && os_valid && is_ts && os_inv && !run_done)
      |=> (run_q == $past(run_q) + W'(1)));
endmodule

// File: rtl/link_poll_seq.sv
module link_poll_seq
   import lps_pkg::*;
#(
   parameter int unsigned LANES        = 8,
   parameter int unsigned QUIET_CYCLES = 2400000,
   parameter int unsigned TX_TARGET    = 1024,
   parameter int unsigned RUN_LEN      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LANES-1:0]   rx_present,
   input  logic [LANES-1:0]   eidle_exit,
   input  logic [LANES-1:0]   os_valid,
   input  logic [2*LANES-1:0] os_kind,
   input  logic [LANES-1:0]   os_inverted,
   input  logic               ts1_sent,
   output logic [1:0]         ltssm_state,
   output logic [LANES-1:0]   tx_lane_en,
   output logic               poll_done
);
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("link_poll_seq: LANES must be 1 to 8");
   end

   lseq_state_t      state_q, state_d;
   logic [LANES-1:0] mask_q;
   logic [LANES-1:0] run_done;
   logic             quiet_done, tx_done, all_runs;
   logic             in_quiet, in_detect, in_poll;

   assign in_quiet  = (state_q == LS_QUIET);
   assign in_detect = (state_q == LS_DETECT);
   assign in_poll   = (state_q == LS_POLL);

   lps_sat_ctr #(.LIMIT(QUIET_CYCLES)) u_quiet_tmr (
      .clk (clk), .rst_n (rst_n),
      .clr (!in_quiet), .inc (in_quiet),
      .done (quiet_done)
   );

   lps_sat_ctr #(.LIMIT(TX_TARGET)) u_tx_cnt (
      .clk (clk), .rst_n (rst_n),
      .clr (in_detect), .inc (in_poll && ts1_sent),
      .done (tx_done)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      lps_lane_run #(.RUN_LEN(RUN_LEN)) u_run (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (in_detect),
         .en       (in_poll),
         .os_valid (os_valid[g]),
         .os_kind  (os_kind[2*g +: 2]),
         .os_inv   (os_inverted[g]),
         .run_done (run_done[g])
      );
   end

   assign all_runs = &(run_done | ~mask_q);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LS_QUIET:  if (quiet_done || (|eidle_exit)) state_d = LS_DETECT;
         LS_DETECT: state_d = (|rx_present) ? LS_POLL : LS_QUIET;
         LS_POLL:   if (tx_done && all_runs) state_d = LS_CFG;
         LS_CFG:    state_d = LS_CFG;
         default:   state_d = LS_QUIET;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LS_QUIET;
         mask_q  <= '0;
      end else begin
         state_q <= state_d;
         if (in_detect) mask_q <= rx_present;
      end
   end

   assign ltssm_state = state_q;
   assign tx_lane_en  = (state_q == LS_POLL || state_q == LS_CFG) ? mask_q : '0;
   assign poll_done   = (state_q == LS_CFG);

   // R4: active detect never lasts two cycles
   p_detect_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_detect |=> (state_q != LS_DETECT));

   // R2: quiet holds while neither the timer nor an idle exit fires
   p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_quiet && !quiet_done && !(|eidle_exit)) |=> (state_q == LS_QUIET));

   // R6: no exit before the sent count is complete
   p_tx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_poll && !tx_done) |=> (state_q == LS_POLL));

   // R7: no exit while a masked lane run is short
   p_run_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_poll && !all_runs) |=> (state_q == LS_POLL));

   // R10: configuration is held until reset
   p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LS_CFG) |=> (state_q == LS_CFG && poll_done));
endmodule

// File: tb/test_link_poll_seq.sv
`timescale 1ns/1ps
module test_link_poll_seq;
   localparam int LN   = 4;
   localparam int QC   = 12;
   localparam int TXN  = 10;
   localparam int RUNL = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [LN-1:0] rx_present, eidle_exit, os_valid, os_inverted;
   logic [2*LN-1:0] os_kind;
   logic          ts1_sent;
   logic [1:0]    ltssm_state;
   logic [LN-1:0] tx_lane_en;
   logic          poll_done;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   link_poll_seq #(.LANES(LN), .QUIET_CYCLES(QC), .TX_TARGET(TXN), .RUN_LEN(RUNL))
   i_link_poll_seq (
      .clk (clk), .rst_n (rst_n), .rx_present (rx_present),
      .eidle_exit (eidle_exit), .os_valid (os_valid), .os_kind (os_kind),
      .os_inverted (os_inverted), .ts1_sent (ts1_sent),
      .ltssm_state (ltssm_state), .tx_lane_en (tx_lane_en), .poll_done (poll_done)
   );

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // one rising edge, return at the falling edge with strobes cleared
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      eidle_exit = '0; os_valid = '0; ts1_sent = 1'b0; os_inverted = '0; os_kind = '0;
   endtask

   task automatic drive_sets(logic [LN-1:0] lanes, logic [1:0] kind, logic inv);
      os_valid = lanes;
      for (int i = 0; i < LN; i++) begin
         os_kind[2*i +: 2] = kind;
         os_inverted[i]    = inv;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rx_present = '0; eidle_exit = '0; os_valid = '0;
      os_kind = '0; os_inverted = '0; ts1_sent = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // from quiet: idle exit, detect with mask m
   task automatic enter_poll(logic [LN-1:0] m);
      rx_present = m;
      eidle_exit = 4'b0001;
      cyc();
      cyc();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
   end

   initial begin
      do_reset();
      // R1 reset values
      chk("R1 state", ltssm_state, 0);
      chk("R1 txen", tx_lane_en, 0);
      chk("R1 done", poll_done, 0);

      // R2 timeout after QC edges, detect on the next
      repeat (QC) cyc();
      chk("R2 still quiet", ltssm_state, 0);
      cyc();
      chk("R2 detect", ltssm_state, 1);
      chk("R5 txen off in detect", tx_lane_en, 0);
      // R4 no receivers -> quiet, timer restarts
      cyc();
      chk("R4 back to quiet", ltssm_state, 0);
      repeat (QC) cyc();
      chk("R4 timer restarted", ltssm_state, 0);
      cyc();
      chk("R4 detect again", ltssm_state, 1);

      // R3 idle exit on each lane
      for (int l = 0; l < LN; l++) begin
         do_reset();
         cyc(); cyc();
         eidle_exit = LN'(1) << l;
         cyc();
         chk("R3 early detect", ltssm_state, 1);
      end

      // sweep all non-empty receiver masks
      for (int m = 1; m < (1 << LN); m++) begin
         do_reset();
         enter_poll(LN'(m));
         chk("R5 poll state", ltssm_state, 2);
         chk("R5 txen mask", tx_lane_en, m);
         // R8 mixed kinds, some inverted; R7 garbage on unmasked lanes
         for (int i = 0; i < RUNL; i++) begin
            drive_sets(LN'(m), (i % 2) ? 2'b10 : 2'b01, (i % 3) == 0);
            os_valid = {LN{1'b1}};
            for (int l = 0; l < LN; l++)
               if (!m[l]) os_kind[2*l +: 2] = 2'b11;
            ts1_sent = 1'b1;
            cyc();
         end
         // R6 runs complete, only RUNL of TXN sent
         cyc();
         chk("R6 held by tx count", ltssm_state, 2);
         for (int i = RUNL; i < TXN; i++) begin
            ts1_sent = 1'b1;
            cyc();
         end
         chk("R6 count just reached", ltssm_state, 2);
         cyc();
         chk("R10 cfg", ltssm_state, 3);
         chk("R10 done", poll_done, 1);
         chk("R8 mixed inverted counted", ltssm_state, 3);
         drive_sets(LN'(m), 2'b00, 1'b0);
         repeat (3) cyc();
         chk("R10 sticky", ltssm_state, 3);
         chk("R5 txen in cfg", tx_lane_en, m);
      end

      // R9 / R7: break run on lane1 after tx count complete
      do_reset();
      enter_poll(4'b0011);
      for (int i = 0; i < TXN; i++) begin
         ts1_sent = 1'b1;
         cyc();
      end
      for (int i = 0; i < 5; i++) begin
         drive_sets(4'b0011, 2'b01, 1'b0);
         cyc();
      end
      drive_sets(4'b0011, 2'b01, 1'b0);
      os_kind[3:2] = 2'b00;
      cyc();
      for (int i = 0; i < RUNL - 1; i++) begin
         drive_sets(4'b0011, 2'b10, 1'b0);
         cyc();
      end
      cyc();
      chk("R9 run cleared by non-TS", ltssm_state, 2);
      chk("R7 waits slow lane", poll_done, 0);
      drive_sets(4'b0010, 2'b01, 1'b1);
      cyc();
      chk("R9 run complete at edge", ltssm_state, 2);
      cyc();
      chk("R7 exit when all masked lanes done", ltssm_state, 3);

      report();
   end
endmodule